// File: doc/BRIEF.md
# Ping-Pong Pipe Buffer-Ready Interrupt Generator

This block decides when one endpoint pipe of a USB function controller should tell the CPU that a packet buffer needs service. It follows the occupancy of up to two packet buffers. Each buffer is empty, partly filled, or ready. Two pointers track which buffer the bus engine works on and which one the CPU works on. The block turns bus events, CPU strobes and software commands into state changes and into a buffer-ready interrupt request.

The conditions that raise the request depend on the pipe configuration:

- transfer direction;
- single or double buffering;
- a read-completion mode, which holds the request back until the CPU has read the end of a transfer;
- a continuous mode, in which one buffer holds several max-size packets;
- a flag that marks the pipe as the default control pipe.

All requests that arise in one cycle merge into a single registered pulse. That pulse also sets a sticky status bit, which software clears by writing 1.

No data moves through this block. Every pin is a plain level or a one-cycle strobe sampled on the rising clock edge, so there is no valid/ready handshake and no back-pressure. A strobe that meets a buffer in the wrong state is dropped. For example, a packet that arrives while the bus-side buffer is still ready is dropped, and so is a commit to a buffer that is already ready.

Top module: `pipe_rdy_irq`

## Requirements
- R1: In receive direction with single buffering and read-completion mode off, completing the bus-side buffer raises the interrupt. The buffer completes on a short packet, a zero-length packet, a full buffer, or a transfer-count end that arrives while the buffer is partly filled. A CPU read-done or CPU clear frees the buffer without raising it.
- R2: In non-continuous mode one full-size packet makes the buffer ready. In continuous mode a buffer becomes ready after PKT_PER_BUF full-size packets, and stays partly filled before that. A packet that arrives while the bus-side buffer is ready is dropped and changes nothing.
- R3: In receive direction with double buffering, a bus-side completion raises the interrupt only when the other buffer is not ready.
- R4: In receive direction with double buffering, a CPU read-done or CPU clear of a ready buffer raises the interrupt only when the other buffer is also ready.
- R5: In receive direction with double buffering and continuous mode, a swap command makes a partly filled bus-side buffer ready and raises the interrupt. A swap on an empty bus-side buffer has no effect.
- R6: In receive direction with read-completion mode on, the buffering setting does not affect which events interrupt. Only two events raise the interrupt: a zero-length packet reception, and the CPU finishing a buffer that ended with a short packet or with a transfer-count end.
- R7: A 0-to-1 change of the direction bit (1 = transmit), as seen at the clock, raises the interrupt.
- R8: In transmit direction, a write-full, commit or DMA-done makes the CPU-side buffer ready if it is not already ready. With single buffering, the end of a packet transmission raises the interrupt. With double buffering, a buffer made ready raises the interrupt only when the other buffer is not ready, and a finished transmission does not.
- R9: In transmit direction, a flush-all while any buffer is ready, or a bus-side clear while the bus-side buffer is ready, raises the interrupt and empties the buffers concerned.
- R10: For the default control pipe, buffering is always single and no interrupt is raised in transmit direction. With read-completion mode on in transmit direction, no interrupt is raised.
- R11: The pulse is high for exactly one cycle, in the cycle after the triggering edge. Several triggering events in one cycle produce one pulse.
- R12: The status bit is set by the pulse and stays set until irq_clr is sampled high. If set and clear happen in the same cycle, set wins.
- R13: During reset both buffers read EMPTY and both pointers and both interrupt outputs read 0. The buffer status encoding is EMPTY=0, FILLING=1, READY=2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_tx | input | 1 | Direction, 1 = transmit |
| cfg_dbl | input | 1 | Double buffering enable |
| cfg_read_end | input | 1 | Read-completion interrupt mode |
| cfg_cont | input | 1 | Continuous (multi-packet buffer) mode |
| cfg_ctrl | input | 1 | Pipe is the default control pipe |
| rx_pkt | input | 1 | Packet received strobe |
| rx_short | input | 1 | Received packet is short |
| rx_zlp | input | 1 | Received packet has zero length |
| xfer_end | input | 1 | Transfer counter reached its end |
| tx_done | input | 1 | Packet transmission finished |
| cpu_rd_done | input | 1 | CPU finished reading its buffer |
| cpu_wr_full | input | 1 | CPU writes filled its buffer |
| cmd_cpu_clr | input | 1 | Clear CPU-side buffer (receive) |
| cmd_flush_all | input | 1 | Clear both buffers and pointers |
| cmd_bus_clr | input | 1 | Clear bus-side buffer |
| cmd_swap | input | 1 | Hand partly filled bus-side buffer to CPU |
| cmd_commit | input | 1 | Mark CPU-side buffer ready to send |
| dma_done | input | 1 | DMA end, marks CPU-side buffer ready |
| irq_clr | input | 1 | Write-1 clear of the status bit |
| irq_pulse | output | 1 | One-cycle interrupt request |
| irq_sts | output | 1 | Sticky interrupt status |
| buf0_st | output | 2 | Buffer 0 state |
| buf1_st | output | 2 | Buffer 1 state |
| bus_ptr | output | 1 | Buffer used by the bus side |
| cpu_ptr | output | 1 | Buffer used by the CPU side |

## Verification
A wrong buffer state or pointer is visible on buf0_st, buf1_st and the pointers in the cycle after the faulty edge. It also changes the interrupt decision for the next event, because the double-buffer rules look at the other buffer's state, so a missing or extra pulse follows within a cycle or two. Scripted sequences walk each direction, buffering, continuous and read-completion combination through fill, read, clear and swap. After every cycle they compare the pulse and both buffer states with the values hand-derived from the requirements. Directed tests then cover reset, sticky-bit clearing and the collision between set and clear.

// File: rtl/pipe_rdy_pkg.sv
package pipe_rdy_pkg;
  localparam int NUM_BUF = 2;

  typedef enum logic [1:0] {
    BUF_EMPTY = 2'd0,
    BUF_FILL  = 2'd1,
    BUF_READY = 2'd2
  } buf_st_e;

  // State-update actions decoded for one cycle
  typedef struct packed {
    logic flush;      // empty everything, pointers home
    logic bus_clr;    // empty the bus-side buffer
    logic bus_fill;   // bus-side buffer takes a packet, not yet complete
    logic bus_ready;  // bus-side buffer completes (receive)
    logic bus_free;   // bus-side buffer sent (transmit)
    logic bus_last;   // completion ended on short packet or count end
    logic cpu_free;   // CPU-side buffer read or cleared (receive)
    logic cpu_ready;  // CPU-side buffer made ready (transmit)
  } act_t;
endpackage

// File: rtl/pipe_rdy_evt.sv
module pipe_rdy_evt
  import pipe_rdy_pkg::*;
#(
  parameter int PKT_PER_BUF = 2,
  parameter int CNT_W       = 2
) (
  input  logic                  cfg_tx,
  input  logic                  cfg_dbl,
  input  logic                  cfg_read_end,
  input  logic                  cfg_cont,
  input  logic                  cfg_ctrl,
  input  logic                  prev_tx,
  input  logic                  rx_pkt,
  input  logic                  rx_short,
  input  logic                  rx_zlp,
  input  logic                  xfer_end,
  input  logic                  tx_done,
  input  logic                  cpu_rd_done,
  input  logic                  cpu_wr_full,
  input  logic                  cmd_cpu_clr,
  input  logic                  cmd_flush_all,
  input  logic                  cmd_bus_clr,
  input  logic                  cmd_swap,
  input  logic                  cmd_commit,
  input  logic                  dma_done,
  input  buf_st_e [NUM_BUF-1:0] st_q,
  input  logic    [NUM_BUF-1:0] last_q,
  input  logic                  bus_ptr,
  input  logic                  cpu_ptr,
  input  logic [CNT_W-1:0]      cnt_q,
  output act_t                  act,
  output logic                  eff_dbl,
  output logic                  irq_req
);
  logic    rx, rx_ok, pkt_full, rx_end, cnt_only, swap_ok, rd_ok, txd_ok, mk_ok;
  logic    any_ready, rx_norm, tx_en, bus_cmp, last_cpu;
  logic    irq_rx1, irq_rx2, irq_rc, irq_tx;
  buf_st_e st_bus, st_bus_oth, st_cpu, st_cpu_oth;

  assign eff_dbl    = cfg_dbl & ~cfg_ctrl;
  assign rx         = ~cfg_tx;
  assign st_bus     = st_q[bus_ptr];
  assign st_bus_oth = st_q[~bus_ptr];
  assign st_cpu     = st_q[cpu_ptr];
  assign st_cpu_oth = st_q[~cpu_ptr];
  assign last_cpu   = last_q[cpu_ptr];
  assign any_ready  = (st_q[0] == BUF_READY) | (st_q[1] == BUF_READY);

  // receive side
  assign rx_ok    = rx & rx_pkt & (st_bus != BUF_READY);
  assign pkt_full = cfg_cont ? (cnt_q == CNT_W'(PKT_PER_BUF - 1)) : 1'b1;
  assign rx_end   = rx_ok & (rx_short | rx_zlp | pkt_full | xfer_end);
  assign cnt_only = rx & ~rx_pkt & xfer_end & (st_bus == BUF_FILL);
  assign swap_ok  = rx & cmd_swap & eff_dbl & cfg_cont & ~rx_pkt & (st_bus == BUF_FILL);
  assign bus_cmp  = rx_end | cnt_only;
  assign rd_ok    = rx & (cpu_rd_done | cmd_cpu_clr) & (st_cpu == BUF_READY);

  // transmit side
  assign txd_ok = cfg_tx & tx_done & (st_bus == BUF_READY);
  assign mk_ok  = cfg_tx & (cpu_wr_full | cmd_commit | dma_done) & (st_cpu != BUF_READY);

  always_comb begin
    act           = '0;
    act.flush     = cmd_flush_all;
    act.bus_clr   = cmd_bus_clr;
    act.bus_fill  = rx_ok & ~rx_end;
    act.bus_ready = bus_cmp | swap_ok;
    act.bus_free  = txd_ok;
    act.bus_last  = (rx_short & ~rx_zlp) | xfer_end;
    act.cpu_free  = rd_ok;
    act.cpu_ready = mk_ok;
  end

  // interrupt qualification
  assign rx_norm = rx & ~cfg_read_end;
  assign tx_en   = cfg_tx & ~cfg_ctrl & ~cfg_read_end;
  assign irq_rx1 = rx_norm & ~eff_dbl & bus_cmp;
  assign irq_rx2 = rx_norm & eff_dbl &
                   ((bus_cmp & (st_bus_oth != BUF_READY)) |
                    (rd_ok & (st_cpu_oth == BUF_READY)) | swap_ok);
  assign irq_rc  = rx & cfg_read_end & ((rx_ok & rx_zlp) | (rd_ok & last_cpu));
  assign irq_tx  = tx_en & (~prev_tx | (~eff_dbl & txd_ok) |
                   (eff_dbl & mk_ok & (st_cpu_oth != BUF_READY)) |
                   (cmd_flush_all & any_ready) |
                   (cmd_bus_clr & (st_bus == BUF_READY)));
  assign irq_req = irq_rx1 | irq_rx2 | irq_rc | irq_tx;
endmodule

// File: rtl/pipe_rdy_buf.sv
module pipe_rdy_buf
  import pipe_rdy_pkg::*;
#(
  parameter int PKT_PER_BUF = 2,
  parameter int CNT_W       = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  act_t                  act,
  input  logic                  eff_dbl,
  output buf_st_e [NUM_BUF-1:0] st_q,
  output logic    [NUM_BUF-1:0] last_q,
  output logic                  bus_ptr,
  output logic                  cpu_ptr,
  output logic [CNT_W-1:0]      cnt_q
);
  for (genvar i = 0; i < NUM_BUF; i++) begin : g_buf
    buf_st_e st_r;
    logic    last_r, on_bus, on_cpu;
    assign on_bus    = (bus_ptr == 1'(i));
    assign on_cpu    = (cpu_ptr == 1'(i));
    assign st_q[i]   = st_r;
    assign last_q[i] = last_r;

    always_ff @(posedge clk) begin
      if (!rst_n || act.flush) begin
        st_r   <= BUF_EMPTY;
        last_r <= 1'b0;
      end else if (on_cpu && act.cpu_free) begin
        st_r <= BUF_EMPTY;
      end else if (on_cpu && act.cpu_ready) begin
        st_r <= BUF_READY;
      end else if (on_bus && act.bus_clr) begin
        st_r <= BUF_EMPTY;
      end else if (on_bus && act.bus_ready) begin
        st_r   <= BUF_READY;
        last_r <= act.bus_last;
      end else if (on_bus && act.bus_fill) begin
        st_r <= BUF_FILL;
      end else if (on_bus && act.bus_free) begin
        st_r <= BUF_EMPTY;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || act.flush) begin
      bus_ptr <= 1'b0;
      cpu_ptr <= 1'b0;
      cnt_q   <= '0;
    end else begin
      if (eff_dbl && !act.bus_clr && (act.bus_ready || act.bus_free)) bus_ptr <= ~bus_ptr;
      if (eff_dbl && (act.cpu_free || act.cpu_ready)) cpu_ptr <= ~cpu_ptr;
      if (act.bus_clr || act.bus_ready) cnt_q <= '0;
      else if (act.bus_fill) cnt_q <= cnt_q + 1'b1;
    end
  end

  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < CNT_W'(PKT_PER_BUF)) else $error("fill count out of range"); // R2
endmodule

// File: rtl/pipe_rdy_pulse.sv
module pipe_rdy_pulse (
  input  logic clk,
  input  logic rst_n,
  input  logic irq_req,
  input  logic irq_clr,
  output logic irq_pulse,
  output logic irq_sts
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_pulse <= 1'b0;
      irq_sts   <= 1'b0;
    end else begin
      irq_pulse <= irq_req;
      irq_sts   <= irq_req | (irq_sts & ~irq_clr);
    end
  end

  AST_STS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_sts && !irq_clr) |=> irq_sts) else $error("status dropped"); // R12
  AST_STS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_clr && !irq_req) |=> !irq_sts) else $error("status not cleared"); // R12
endmodule

// File: rtl/pipe_rdy_irq.sv
module pipe_rdy_irq
  import pipe_rdy_pkg::*;
#(
  parameter int PKT_PER_BUF = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_tx,
  input  logic       cfg_dbl,
  input  logic       cfg_read_end,
  input  logic       cfg_cont,
  input  logic       cfg_ctrl,
  input  logic       rx_pkt,
  input  logic       rx_short,
  input  logic       rx_zlp,
  input  logic       xfer_end,
  input  logic       tx_done,
  input  logic       cpu_rd_done,
  input  logic       cpu_wr_full,
  input  logic       cmd_cpu_clr,
  input  logic       cmd_flush_all,
  input  logic       cmd_bus_clr,
  input  logic       cmd_swap,
  input  logic       cmd_commit,
  input  logic       dma_done,
  input  logic       irq_clr,
  output logic       irq_pulse,
  output logic       irq_sts,
  output logic [1:0] buf0_st,
  output logic [1:0] buf1_st,
  output logic       bus_ptr,
  output logic       cpu_ptr
);
  localparam int CNT_W = $clog2(PKT_PER_BUF + 1);

  act_t                  act;
  logic                  eff_dbl, irq_req, prev_tx;
  buf_st_e [NUM_BUF-1:0] st_q;
  logic    [NUM_BUF-1:0] last_q;
  logic [CNT_W-1:0]      cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) prev_tx <= 1'b0;
    else        prev_tx <= cfg_tx;
  end

  pipe_rdy_evt #(.PKT_PER_BUF(PKT_PER_BUF), .CNT_W(CNT_W)) i_evt (
    .cfg_tx(cfg_tx), .cfg_dbl(cfg_dbl), .cfg_read_end(cfg_read_end),
    .cfg_cont(cfg_cont), .cfg_ctrl(cfg_ctrl), .prev_tx(prev_tx),
    .rx_pkt(rx_pkt), .rx_short(rx_short), .rx_zlp(rx_zlp), .xfer_end(xfer_end),
    .tx_done(tx_done), .cpu_rd_done(cpu_rd_done), .cpu_wr_full(cpu_wr_full),
    .cmd_cpu_clr(cmd_cpu_clr), .cmd_flush_all(cmd_flush_all),
    .cmd_bus_clr(cmd_bus_clr), .cmd_swap(cmd_swap), .cmd_commit(cmd_commit),
    .dma_done(dma_done), .st_q(st_q), .last_q(last_q), .bus_ptr(bus_ptr),
    .cpu_ptr(cpu_ptr), .cnt_q(cnt_q), .act(act), .eff_dbl(eff_dbl),
    .irq_req(irq_req)
  );

  pipe_rdy_buf #(.PKT_PER_BUF(PKT_PER_BUF), .CNT_W(CNT_W)) i_buf (
    .clk(clk), .rst_n(rst_n), .act(act), .eff_dbl(eff_dbl), .st_q(st_q),
    .last_q(last_q), .bus_ptr(bus_ptr), .cpu_ptr(cpu_ptr), .cnt_q(cnt_q)
  );

  pipe_rdy_pulse i_pulse (
    .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .irq_clr(irq_clr),
    .irq_pulse(irq_pulse), .irq_sts(irq_sts)
  );

  assign buf0_st = st_q[0];
  assign buf1_st = st_q[1];

  AST_CTRL_TX_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_tx && cfg_ctrl) |=> !irq_pulse) else $error("control pipe tx irq"); // R10
  AST_RDEND_TX_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_tx && cfg_read_end) |=> !irq_pulse) else $error("read-end tx irq"); // R10
  AST_PULSE_SETS_STS: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pulse |-> irq_sts) else $error("pulse without status"); // R12
  AST_SINGLE_NO_B1: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_ctrl && !bus_ptr && !cpu_ptr) |=> (!bus_ptr && !cpu_ptr)) else $error("ctrl pipe used second buffer"); // R10
endmodule

// File: tb/test_pipe_rdy_irq.sv
module test_pipe_rdy_irq;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_tx, cfg_dbl, cfg_read_end, cfg_cont, cfg_ctrl;
  logic rx_pkt, rx_short, rx_zlp, xfer_end, tx_done, cpu_rd_done, cpu_wr_full;
  logic cmd_cpu_clr, cmd_flush_all, cmd_bus_clr, cmd_swap, cmd_commit, dma_done, irq_clr;
  logic irq_pulse, irq_sts, bus_ptr, cpu_ptr;
  logic [1:0] buf0_st, buf1_st;
  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  pipe_rdy_irq #(.PKT_PER_BUF(2)) i_pipe_rdy_irq (.*);

  localparam logic [4:0] C_NO = 5'b00000, C_TX = 5'b10000, C_DB = 5'b01000,
                         C_RC = 5'b00100, C_CT = 5'b00010, C_CP = 5'b00001;
  localparam logic [12:0] E_NO = 13'd0, E_RX = 13'h1000, E_SH = 13'h0800,
    E_ZL = 13'h0400, E_TC = 13'h0200, E_TXD = 13'h0100, E_RD = 13'h0080,
    E_WF = 13'h0040, E_BC = 13'h0020, E_AC = 13'h0010, E_SC = 13'h0008,
    E_TG = 13'h0004, E_BV = 13'h0002, E_DM = 13'h0001;
  localparam int NV = 63;
  // {req, cfg, events, exp irq, exp buf0, exp buf1}
  localparam logic [26:0] VEC [NV] = '{
    {4'd1, C_NO, E_RX, 1'b1, 2'd2, 2'd0},            // R1 full packet
    {4'd2, C_NO, E_RX, 1'b0, 2'd2, 2'd0},            // R2 dropped
    {4'd1, C_NO, E_RD, 1'b0, 2'd0, 2'd0},
    {4'd1, C_NO, E_RX|E_SH, 1'b1, 2'd2, 2'd0},
    {4'd1, C_NO, E_BC, 1'b0, 2'd0, 2'd0},
    {4'd2, C_CT, E_RX, 1'b0, 2'd1, 2'd0},            // R2 continuous
    {4'd1, C_CT, E_TC, 1'b1, 2'd2, 2'd0},
    {4'd1, C_CT, E_RD, 1'b0, 2'd0, 2'd0},
    {4'd2, C_CT, E_RX, 1'b0, 2'd1, 2'd0},
    {4'd2, C_CT, E_RX, 1'b1, 2'd2, 2'd0},
    {4'd1, C_CT, E_RD, 1'b0, 2'd0, 2'd0},
    {4'd1, C_CT, E_TC, 1'b0, 2'd0, 2'd0},
    {4'd3, C_DB, E_RX, 1'b1, 2'd2, 2'd0},            // R3
    {4'd3, C_DB, E_RX, 1'b0, 2'd2, 2'd2},
    {4'd2, C_DB, E_RX, 1'b0, 2'd2, 2'd2},
    {4'd4, C_DB, E_RD, 1'b1, 2'd0, 2'd2},            // R4
    {4'd4, C_DB, E_RD, 1'b0, 2'd0, 2'd0},
    {4'd3, C_DB, E_RX|E_SH, 1'b1, 2'd2, 2'd0},
    {4'd3, C_DB, E_RX|E_ZL, 1'b0, 2'd2, 2'd2},
    {4'd4, C_DB, E_BC, 1'b1, 2'd0, 2'd2},
    {4'd4, C_DB, E_RD, 1'b0, 2'd0, 2'd0},
    {4'd2, C_DB|C_CT, E_RX, 1'b0, 2'd1, 2'd0},
    {4'd5, C_DB|C_CT, E_TG, 1'b1, 2'd2, 2'd0},      // R5
    {4'd5, C_DB|C_CT, E_TG, 1'b0, 2'd2, 2'd0},
    {4'd2, C_DB|C_CT, E_RX, 1'b0, 2'd2, 2'd1},
    {4'd3, C_DB|C_CT, E_RX|E_TC, 1'b0, 2'd2, 2'd2},
    {4'd4, C_DB|C_CT, E_RD, 1'b1, 2'd0, 2'd2},
    {4'd4, C_DB|C_CT, E_RD, 1'b0, 2'd0, 2'd0},
    {4'd6, C_RC|C_DB, E_RX, 1'b0, 2'd2, 2'd0},      // R6
    {4'd6, C_RC|C_DB, E_RX|E_SH, 1'b0, 2'd2, 2'd2},
    {4'd6, C_RC|C_DB, E_RD, 1'b0, 2'd0, 2'd2},
    {4'd6, C_RC|C_DB, E_RD, 1'b1, 2'd0, 2'd0},
    {4'd6, C_RC|C_DB, E_RX|E_ZL, 1'b1, 2'd2, 2'd0},
    {4'd6, C_RC|C_DB, E_RD, 1'b0, 2'd0, 2'd0},
    {4'd6, C_RC|C_DB, E_RX|E_TC, 1'b0, 2'd0, 2'd2},
    {4'd6, C_RC|C_DB, E_RD, 1'b1, 2'd0, 2'd0},
    {4'd7, C_TX, E_NO, 1'b1, 2'd0, 2'd0},            // R7
    {4'd8, C_TX, E_WF, 1'b0, 2'd2, 2'd0},            // R8
    {4'd8, C_TX, E_TXD, 1'b1, 2'd0, 2'd0},
    {4'd8, C_TX, E_BV, 1'b0, 2'd2, 2'd0},
    {4'd9, C_TX, E_SC, 1'b1, 2'd0, 2'd0},            // R9
    {4'd9, C_TX, E_SC, 1'b0, 2'd0, 2'd0},
    {4'd8, C_TX, E_DM, 1'b0, 2'd2, 2'd0},
    {4'd9, C_TX, E_AC, 1'b1, 2'd0, 2'd0},
    {4'd8, C_TX|C_DB, E_WF, 1'b1, 2'd2, 2'd0},
    {4'd8, C_TX|C_DB, E_BV, 1'b0, 2'd2, 2'd2},
    {4'd8, C_TX|C_DB, E_WF, 1'b0, 2'd2, 2'd2},
    {4'd8, C_TX|C_DB, E_TXD, 1'b0, 2'd0, 2'd2},
    {4'd8, C_TX|C_DB, E_DM, 1'b0, 2'd2, 2'd2},
    {4'd8, C_TX|C_DB, E_TXD, 1'b0, 2'd2, 2'd0},
    {4'd8, C_TX|C_DB, E_TXD, 1'b0, 2'd0, 2'd0},
    {4'd8, C_TX|C_DB, E_DM, 1'b1, 2'd0, 2'd2},
    {4'd9, C_TX|C_DB, E_AC, 1'b1, 2'd0, 2'd0},
    {4'd10, C_TX|C_RC, E_WF, 1'b0, 2'd2, 2'd0},     // R10
    {4'd10, C_TX|C_RC, E_TXD, 1'b0, 2'd0, 2'd0},
    {4'd10, C_CP, E_RX|E_SH, 1'b1, 2'd2, 2'd0},
    {4'd10, C_CP, E_RD, 1'b0, 2'd0, 2'd0},
    {4'd10, C_TX|C_CP, E_NO, 1'b0, 2'd0, 2'd0},
    {4'd10, C_TX|C_CP, E_WF, 1'b0, 2'd2, 2'd0},
    {4'd10, C_TX|C_CP, E_TXD, 1'b0, 2'd0, 2'd0},
    {4'd8, C_TX, E_WF, 1'b0, 2'd2, 2'd0},
    {4'd11, C_TX, E_SC|E_AC, 1'b1, 2'd0, 2'd0},     // R11 merged
    {4'd11, C_TX, E_NO, 1'b0, 2'd0, 2'd0}
  };

  task automatic drive(input logic [4:0] c, input logic [12:0] e, input logic clr);
    {cfg_tx, cfg_dbl, cfg_read_end, cfg_cont, cfg_ctrl} = c;
    {rx_pkt, rx_short, rx_zlp, xfer_end, tx_done, cpu_rd_done, cpu_wr_full,
     cmd_cpu_clr, cmd_flush_all, cmd_bus_clr, cmd_swap, cmd_commit, dma_done} = e;
    irq_clr = clr;
  endtask

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  initial begin
    drive(C_NO, E_NO, 1'b0);
    repeat (3) @(negedge clk);
    // R13 reset state
    chk("R13", "buf0", buf0_st, 0); chk("R13", "buf1", buf1_st, 0);
    chk("R13", "ptrs", {bus_ptr, cpu_ptr}, 0);
    chk("R13", "irq", {irq_pulse, irq_sts}, 0);
    rst_n = 1'b1;
    for (int i = 0; i < NV; i++) begin
      string r;
      r = $sformatf("R%0d#%0d", VEC[i][26:23], i + 1);
      drive(VEC[i][22:18], VEC[i][17:5], 1'b0);
      @(negedge clk);
      chk(r, "pulse", irq_pulse, VEC[i][4]);
      chk(r, "buf0", buf0_st, VEC[i][3:2]);
      chk(r, "buf1", buf1_st, VEC[i][1:0]);
    end
    // R12 sticky, write-1 clear, set wins
    drive(C_TX, E_NO, 1'b0);
    chk("R12", "sticky", irq_sts, 1);
    drive(C_TX, E_NO, 1'b1);
    @(negedge clk);
    chk("R12", "cleared", irq_sts, 0);
    drive(C_TX, E_WF, 1'b0);
    @(negedge clk);
    chk("R12", "no set", irq_sts, 0);
    drive(C_TX, E_TXD, 1'b1);
    @(negedge clk);
    chk("R11", "pulse", irq_pulse, 1);
    chk("R12", "set wins", irq_sts, 1);
    drive(C_TX, E_NO, 1'b0);
    @(negedge clk);
    chk("R11", "one cycle", irq_pulse, 0);
    chk("R12", "held", irq_sts, 1);
    // R13 reset from busy state
    drive(C_DB, E_RX, 1'b0);
    @(negedge clk);
    drive(C_DB, E_NO, 1'b0);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R13", "buf0 rst", buf0_st, 0);
    chk("R13", "ptr rst", {bus_ptr, cpu_ptr}, 0);
    chk("R13", "sts rst", irq_sts, 0);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule